// File: doc/BRIEF.md
# Radio Transmit Start Sequencer

This block sequences the start and end of a single radio transmission. While the radio controller reports one of its two ready states, the block waits for a start request. A request can come either from a rising edge on a dedicated start bit or from a transmit-start code written to a command field. Once it accepts a request, it runs a fixed sequence: a power-amplifier ramp-up with an unmodulated carrier, a data phase in which the baseband modulator is enabled, and a ramp-down with an unmodulated carrier again.

During each ramp the synthesizer may be offset by +500 kHz or -500 kHz from the channel frequency. The up-ramp and the down-ramp have separate offset selects. The ramp-up always lasts a parameterised number of clock cycles, `LEAD_CYCLES`. Its default of 3200 cycles at 200 MHz places the start of modulation 16 µs after the trigger. The ramp-down length is taken from a configuration field.

The transmit power level is forwarded to the amplifier control unchanged. The level field spans the amplifier's 20 dB range.

Top module: `txseq_top`

## Requirements
- R1: A start request is accepted only while `radioState` equals 3'd1 (PLL ready) or 3'd2 (auto-retry transmit ready). Requests in any other state leave `busy` and `paEnable` low.
- R2: Either of two triggers starts a transmission: a rising edge of `startBit` (a 0 in one cycle followed by a 1 in the next), or `cmdWrite` high with `cmdCode` equal to 4'h2. A `cmdWrite` with any other code is ignored.
- R3: `paEnable` and `busy` go high in the cycle after the clock edge that accepts a trigger. They stay high through the end of the ramp-down.
- R4: `modEnable` is low throughout the ramp-up and the ramp-down, and is high only in the data phase.
- R5: `offsetSel` uses 2'b01 for +500 kHz, 2'b10 for -500 kHz and 2'b00 for no offset. During the ramp-up it follows `upOffsetNeg` (1 selects -500 kHz). During the ramp-down it follows `downOffsetNeg`. It is 2'b00 in the data phase and in idle.
- R6: `modEnable` goes high exactly `LEAD_CYCLES` clock cycles after the edge that accepted the trigger.
- R7: `dataDone` sampled high in the data phase starts the ramp-down. The ramp-down lasts `rampDownLen`+1 cycles, using the value of `rampDownLen` captured together with `dataDone`.
- R8: `done` is a one-cycle pulse in the first idle cycle after the ramp-down, the cycle in which `busy` has just fallen.
- R9: Start requests that arrive while `busy` is high are ignored and do not disturb the sequence timing. A `startBit` held high after a transmission does not start another one.
- R10: `paPower` equals `powerLevel` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| radioState | input | 3 | Current radio controller state code |
| startBit | input | 1 | Start control bit, rising-edge triggered |
| cmdWrite | input | 1 | Command field write strobe |
| cmdCode | input | 4 | Command code; 4'h2 requests a transmit start |
| upOffsetNeg | input | 1 | Ramp-up offset select, 1 = -500 kHz |
| downOffsetNeg | input | 1 | Ramp-down offset select, 1 = -500 kHz |
| rampDownLen | input | 8 | Ramp-down length minus one, in cycles |
| powerLevel | input | 4 | Transmit power level field |
| dataDone | input | 1 | Baseband signals the end of frame data |
| paEnable | output | 1 | Power amplifier enable |
| modEnable | output | 1 | Baseband modulation enable |
| offsetSel | output | 2 | Synthesizer offset select |
| paPower | output | 4 | Power level forwarded to the amplifier control |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to produce from the ports is a second trigger during a sequence that is already running. To be a real test, it has to be a fresh rising edge rather than a held level. The stimulus drops `startBit` and raises it again in the middle of the ramp-up, and it also writes the start command there and during the data phase. The exact cycle on which modulation starts, and the exact cycle on which `done` pulses, then show that neither sequence restarted. Changing `rampDownLen` right after `dataDone` checks that the captured value, not the live one, sets the ramp-down length.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RAMPUP, ST_DATA, ST_RAMPDN} seqState_t;

  typedef struct packed {
    logic cntClr;
    logic dnLoad;
  } seqStrobe_t;

  localparam logic [2:0] RADIO_PLL_READY   = 3'd1;
  localparam logic [2:0] RADIO_RETRY_READY = 3'd2;
  localparam logic [3:0] CMD_TX_START      = 4'h2;
endpackage

// File: rtl/txseq_dp.sv
module txseq_dp
  import txseq_pkg::*;
#(
  parameter int LEAD_CYCLES = 3200,
  parameter int DN_W        = 8,
  parameter int CNT_W       = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strobe,
  input  logic            startBit,
  input  logic            cmdWrite,
  input  logic [3:0]      cmdCode,
  input  logic [DN_W-1:0] rampDownLen,
  output logic            trigger,
  output logic            leadDone,
  output logic            dnDone
);
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_CYCLES - 1);

  logic             startPrev;
  logic [CNT_W-1:0] cnt;
  logic [DN_W-1:0]  dnLenQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPrev <= 1'b0;
      cnt       <= '0;
      dnLenQ    <= '0;
    end else begin
      startPrev <= startBit;
      cnt       <= strobe.cntClr ? '0 : cnt + 1'b1;
      if (strobe.dnLoad) dnLenQ <= rampDownLen;
    end
  end

  assign trigger  = (startBit && !startPrev) || (cmdWrite && cmdCode == CMD_TX_START);
  assign leadDone = (cnt == LEAD_LAST);
  assign dnDone   = (cnt == {{(CNT_W-DN_W){1'b0}}, dnLenQ});

  // R2: a trigger needs one of the two request inputs
  p_trigger_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> (startBit || cmdWrite));

  // R7: the captured ramp-down length is held while the counter runs
  p_dnlen_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dnLoad |=> $stable(dnLenQ));
endmodule

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
  import txseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] radioState,
  input  logic       trigger,
  input  logic       leadDone,
  input  logic       dnDone,
  input  logic       dataDone,
  input  logic       upOffsetNeg,
  input  logic       downOffsetNeg,
  output seqStrobe_t strobe,
  output logic       paEnable,
  output logic       modEnable,
  output logic [1:0] offsetSel,
  output logic       busy,
  output logic       done
);
  seqState_t stateQ, stateD;
  logic      legal;
  logic      doneQ;

  assign legal = (radioState == RADIO_PLL_READY) || (radioState == RADIO_RETRY_READY);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (trigger && legal) stateD = ST_RAMPUP;
      ST_RAMPUP: if (leadDone)         stateD = ST_DATA;
      ST_DATA:   if (dataDone)         stateD = ST_RAMPDN;
      ST_RAMPDN: if (dnDone)           stateD = ST_IDLE;
      default:                         stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= (stateQ == ST_RAMPDN) && dnDone;
    end
  end

  always_comb begin
    strobe.cntClr = (stateQ != ST_RAMPUP) && (stateQ != ST_RAMPDN);
    strobe.dnLoad = (stateQ == ST_DATA) && dataDone;
  end

  assign paEnable  = (stateQ != ST_IDLE);
  assign busy      = (stateQ != ST_IDLE);
  assign modEnable = (stateQ == ST_DATA);
  assign done      = doneQ;

  always_comb begin
    unique case (stateQ)
      ST_RAMPUP: offsetSel = upOffsetNeg   ? 2'b10 : 2'b01;
      ST_RAMPDN: offsetSel = downOffsetNeg ? 2'b10 : 2'b01;
      default:   offsetSel = 2'b00;
    endcase
  end

  // R1: without a legal ready state, idle is kept
  p_illegal_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !legal) |=> (stateQ == ST_IDLE));

  // R4: modulation implies amplifier on and no ramp offset
  p_mod_needs_pa_r4: assert property (@(posedge clk) disable iff (!rstN)
    modEnable |-> (paEnable && offsetSel == 2'b00));

  // R6: data phase is entered only when the lead count expired
  p_lead_expired_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modEnable) |-> $past(leadDone));

  // R8: done is a single pulse seen only when idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy ##1 !done));

  // R9: a running sequence does not jump back to ramp-up
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DATA || stateQ == ST_RAMPDN) |=> (stateQ != ST_RAMPUP));
endmodule

// File: rtl/txseq_top.sv
module txseq_top
  import txseq_pkg::*;
#(
  parameter int LEAD_CYCLES = 3200,
  parameter int DN_W        = 8,
  parameter int PWR_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       radioState,
  input  logic             startBit,
  input  logic             cmdWrite,
  input  logic [3:0]       cmdCode,
  input  logic             upOffsetNeg,
  input  logic             downOffsetNeg,
  input  logic [DN_W-1:0]  rampDownLen,
  input  logic [PWR_W-1:0] powerLevel,
  input  logic             dataDone,
  output logic             paEnable,
  output logic             modEnable,
  output logic [1:0]       offsetSel,
  output logic [PWR_W-1:0] paPower,
  output logic             busy,
  output logic             done
);
  localparam int CNT_W = $clog2(LEAD_CYCLES + (1 << DN_W));

  seqStrobe_t strobe;
  logic       trigger, leadDone, dnDone;

  txseq_dp #(.LEAD_CYCLES(LEAD_CYCLES), .DN_W(DN_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startBit(startBit),
    .cmdWrite(cmdWrite), .cmdCode(cmdCode), .rampDownLen(rampDownLen),
    .trigger(trigger), .leadDone(leadDone), .dnDone(dnDone)
  );

  txseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .radioState(radioState), .trigger(trigger),
    .leadDone(leadDone), .dnDone(dnDone), .dataDone(dataDone),
    .upOffsetNeg(upOffsetNeg), .downOffsetNeg(downOffsetNeg),
    .strobe(strobe), .paEnable(paEnable), .modEnable(modEnable),
    .offsetSel(offsetSel), .busy(busy), .done(done)
  );

  assign paPower = powerLevel;

  // R10: the level reaches the amplifier unchanged
  p_power_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    paPower == powerLevel);
endmodule

// File: tb/tb_txseq_top.sv
module tb_txseq_top;
  localparam int LEAD = 3200;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] radioState;
  logic       startBit, cmdWrite, upOffsetNeg, downOffsetNeg, dataDone;
  logic [3:0] cmdCode, powerLevel, paPower;
  logic [7:0] rampDownLen;
  logic       paEnable, modEnable, busy, done;
  logic [1:0] offsetSel;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  txseq_top #(.LEAD_CYCLES(LEAD)) dut (
    .clk(clk), .rstN(rstN), .radioState(radioState), .startBit(startBit),
    .cmdWrite(cmdWrite), .cmdCode(cmdCode), .upOffsetNeg(upOffsetNeg),
    .downOffsetNeg(downOffsetNeg), .rampDownLen(rampDownLen),
    .powerLevel(powerLevel), .dataDone(dataDone), .paEnable(paEnable),
    .modEnable(modEnable), .offsetSel(offsetSel), .paPower(paPower),
    .busy(busy), .done(done)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R3 reset paEnable", paEnable, 0);
    chk("R3 reset busy", busy, 0);
    chk("R4 reset modEnable", modEnable, 0);
    chk("R5 reset offsetSel", offsetSel, 0);
    chk("R8 reset done", done, 0);
  endtask

  // one full transmission; poke injects extra requests while busy (R9)
  task automatic runFrame(bit useBit, logic [2:0] st, bit upNeg, bit dnNeg,
                          int len, bit poke);
    int upExp = upNeg ? 2 : 1;
    int dnExp = dnNeg ? 2 : 1;
    radioState = st; upOffsetNeg = upNeg; downOffsetNeg = dnNeg;
    if (useBit) startBit = 1'b1;
    else begin cmdWrite = 1'b1; cmdCode = 4'h2; end
    step(1);
    cmdWrite = 1'b0;
    chk("R3 paEnable after trigger", paEnable, 1);
    chk("R3 busy after trigger", busy, 1);
    chk("R4 mod low in ramp-up", modEnable, 0);
    chk("R5 ramp-up offset", offsetSel, upExp);
    if (poke) begin
      step(9);
      startBit = 1'b0;
      step(1);
      startBit = 1'b1; cmdWrite = 1'b1; cmdCode = 4'h2;
      step(1);
      cmdWrite = 1'b0;
      step(LEAD - 12);
    end else step(LEAD - 1);
    chk("R6 mod still low at lead-1", modEnable, 0);
    chk("R5 offset at end of ramp-up", offsetSel, upExp);
    step(1);
    chk("R6 mod high at lead", modEnable, 1);
    chk("R5 no offset in data", offsetSel, 0);
    step(4);
    if (poke) begin
      cmdWrite = 1'b1; step(1); cmdWrite = 1'b0;
      chk("R9 data unaffected by request", modEnable, 1);
    end
    dataDone = 1'b1; rampDownLen = 8'(len);
    step(1);
    dataDone = 1'b0; rampDownLen = 8'(len + 7);
    chk("R4 mod low in ramp-down", modEnable, 0);
    chk("R5 ramp-down offset", offsetSel, dnExp);
    chk("R3 paEnable in ramp-down", paEnable, 1);
    step(len);
    chk("R7 pa on at last ramp-down cycle", paEnable, 1);
    chk("R8 no done before end", done, 0);
    step(1);
    chk("R7 pa off after ramp-down", paEnable, 0);
    chk("R3 busy falls", busy, 0);
    chk("R8 done pulse", done, 1);
    step(1);
    chk("R8 done one cycle", done, 0);
    step(3);
    chk("R9 held start bit no retrigger", busy, 0);
    startBit = 1'b0;
    step(1);
  endtask

  task automatic tryReject(logic [2:0] st, bit useBit, logic [3:0] code, string req);
    radioState = st;
    if (useBit) startBit = 1'b1;
    else begin cmdWrite = 1'b1; cmdCode = code; end
    step(1);
    startBit = 1'b0; cmdWrite = 1'b0;
    step(2);
    chk(req, busy, 0);
    chk(req, paEnable, 0);
  endtask

  task automatic testPower();
    for (int v = 0; v < 16; v += 5) begin
      powerLevel = 4'(v);
      #1;
      chk("R10 power passthrough", paPower, v);
    end
  endtask

  initial begin
    rstN = 1'b0; radioState = 3'd0; startBit = 1'b0; cmdWrite = 1'b0;
    cmdCode = 4'h0; upOffsetNeg = 1'b0; downOffsetNeg = 1'b0;
    rampDownLen = 8'd0; powerLevel = 4'd9; dataDone = 1'b0;
    step(3);
    rstN = 1'b1;
    step(1);
    testReset();
    runFrame(1'b1, 3'd1, 1'b0, 1'b1, 3, 1'b0);
    runFrame(1'b0, 3'd2, 1'b1, 1'b0, 0, 1'b1);
    runFrame(1'b1, 3'd2, 1'b1, 1'b1, 20, 1'b1);
    tryReject(3'd0, 1'b1, 4'h0, "R1 bit rejected in state 0");
    tryReject(3'd4, 1'b0, 4'h2, "R1 cmd rejected in state 4");
    tryReject(3'd3, 1'b1, 4'h0, "R1 bit rejected in state 3");
    tryReject(3'd1, 1'b0, 4'h3, "R2 wrong command code");
    testPower();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule